// File: doc/BRIEF.md
# Nibble-Bus Memory Target (LPC / FWH framing)

This block is the target side of a 4-bit multiplexed host bus that also carries an active-low frame strobe. On every rising clock edge it samples the strobe and the four data lines. The value of the start nibble picks one of two framing protocols for the rest of the cycle. It then gathers the header nibble, the address and, on writes, the data byte. After the host's turnaround it drives sync nibbles while its internal access completes. On reads it then returns the byte, low nibble first. It ends with its own turnaround and releases the lines.

The storage behind the bus is a small byte-wide register array with a synchronous read/write port, indexed by the low address bits. Up to eight targets can share one bus, and each is told apart by a 3-bit strap. In the LPC framing the target claims a cycle only when address bits [21:19] equal the bitwise inverse of the strap. In the FWH framing it claims a cycle only when the ID-select nibble equals the strap value. The bus is modelled as separate input, output and output-enable ports; a pad wrapper joins them into the shared lines.

Top module: `lpc_fwh_target`

## Requirements
- R1: After reset the output enable is low and every storage byte reads as 0x00.
- R2: With frame low, the start nibble 0000 selects LPC framing, 1101 selects an FWH read and 1110 selects an FWH write. Any other value leaves the target idle. When frame stays low for several clocks, the nibble on the last low clock counts.
- R3: In LPC framing the header nibble 0100 is a memory read and 0110 is a memory write. Any other header makes the target ignore the cycle.
- R4: An LPC address is eight nibbles, most significant first. The target responds only when address bits [21:19] equal the inverse of the strap, and it indexes storage with the low address bits.
- R5: In FWH framing the header nibble is an ID select. The target responds only if it equals {0, strap}. Seven address nibbles follow, most significant first.
- R6: After the FWH address comes a size nibble. Only 0000 (one byte) is served, and any other size is ignored.
- R7: The output enable stays low while the host sends start, header, address, write data and its two turnaround clocks, and also for the whole length of any cycle that is ignored.
- R8: After the host turnaround, the target drives sync 0101 for WAIT_CLKS clocks and then sync 0000 for one clock.
- R9: On a read, the two clocks after the ready sync carry data bits [3:0] and then bits [7:4].
- R10: On a write, the byte is taken low nibble first. A later read of the same index returns it.
- R11: After its last data or sync nibble, the target drives 1111 for one clock and then drops the output enable.
- R12: A frame-low clock at any point in a cycle aborts it. From the next clock the bus is released, an unfinished write changes nothing, and that clock's nibble is judged as a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising-edge sampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low cycle frame strobe |
| bus_in | input | 4 | Nibble sampled from the shared data lines |
| bus_out | output | 4 | Nibble the target drives onto the lines |
| bus_oe | output | 1 | High while the target drives the lines |
| id_strap | input | 3 | Target select strap |

## Verification
The bench sweeps every start nibble, every LPC header, all eight values of address bits [21:19], every ID select and every size nibble. A target that decoded any of them too loosely would drive the bus or corrupt a byte that a later read-back checks. Aborts are placed mid-address on a write and in the middle of sync. A design that finished the aborted write, kept driving, or missed the new start would be caught at the ports. Every response nibble is compared clock by clock. This catches a sync count that is off by one, swapped data nibbles, and a missing 1111 or a late release.

// File: rtl/lpc_target_pkg.sv
package lpc_target_pkg;

    localparam int NIB_W   = 4;
    localparam int ADDR_W  = 32;
    localparam int WAIT_W  = 8;
    localparam int CNT_W   = 4;

    localparam logic [3:0] START_LPC    = 4'b0000;
    localparam logic [3:0] START_FWH_RD = 4'b1101;
    localparam logic [3:0] START_FWH_WR = 4'b1110;
    localparam logic [3:0] HDR_MEM_RD   = 4'b0100;
    localparam logic [3:0] HDR_MEM_WR   = 4'b0110;
    localparam logic [3:0] SIZE_BYTE    = 4'b0000;
    localparam logic [3:0] SYNC_WAIT    = 4'b0101;
    localparam logic [3:0] SYNC_READY   = 4'b0000;
    localparam logic [3:0] NIB_TAR      = 4'b1111;

    localparam logic [CNT_W-1:0] LPC_ADDR_LAST = 4'd7;
    localparam logic [CNT_W-1:0] FWH_ADDR_LAST = 4'd6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR,
        ST_ADDR,
        ST_SIZE,
        ST_WDATA,
        ST_TAR_IN,
        ST_SYNC,
        ST_RDATA,
        ST_TAR_OUT,
        ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e          state;
        logic                is_fwh;
        logic                is_wr;
        logic [CNT_W-1:0]    cnt;
        logic [ADDR_W-1:0]   addr;
        logic [7:0]          wdata;
        logic [WAIT_W-1:0]   wait_cnt;
    } tgt_ctl_t;

endpackage

// File: rtl/lpc_start_decode.sv
module lpc_start_decode
    import lpc_target_pkg::*;
(
    input  logic [NIB_W-1:0] nib,
    output logic             valid,
    output logic             is_fwh,
    output logic             is_wr
);
    always_comb begin
        valid  = 1'b0;
        is_fwh = 1'b0;
        is_wr  = 1'b0;
        unique case (nib)
            START_LPC:    valid = 1'b1;
            START_FWH_RD: begin valid = 1'b1; is_fwh = 1'b1; end
            START_FWH_WR: begin valid = 1'b1; is_fwh = 1'b1; is_wr = 1'b1; end
            default:      valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/lpc_byte_store.sv
module lpc_byte_store #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);
    logic [7:0] cells_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells_q[i] <= 8'h00;
            rdata <= 8'h00;
        end else begin
            if (wr_en) cells_q[idx] <= wdata;
            if (rd_en) rdata <= cells_q[idx];
        end
    end

    // R10: the bus engine never asks for a read and a write in the same clock
    assert_single_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_en, wr_en}));
endmodule

// File: rtl/lpc_fwh_target.sv
module lpc_fwh_target
    import lpc_target_pkg::*;
#(
    parameter int WAIT_CLKS = 2,
    parameter int DEPTH     = 16,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic [NIB_W-1:0] bus_in,
    output logic [NIB_W-1:0] bus_out,
    output logic             bus_oe,
    input  logic [2:0]       id_strap
);
    tgt_ctl_t ctl_d, ctl_q;

    logic             start_valid, start_fwh, start_wr;
    logic             acc_rd, acc_wr;
    logic [7:0]       store_rdata;
    logic [ADDR_W-1:0] addr_next;
    logic             unused_addr;

    lpc_start_decode u_start (
        .nib    (bus_in),
        .valid  (start_valid),
        .is_fwh (start_fwh),
        .is_wr  (start_wr)
    );

    lpc_byte_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (acc_rd),
        .wr_en (acc_wr),
        .idx   (ctl_q.addr[IDX_W-1:0]),
        .wdata (ctl_q.wdata),
        .rdata (store_rdata)
    );

    assign addr_next   = {ctl_q.addr[ADDR_W-NIB_W-1:0], bus_in};
    assign unused_addr = ^ctl_q.addr;

    always_comb begin
        ctl_d  = ctl_q;
        acc_rd = 1'b0;
        acc_wr = 1'b0;
        if (!frame_n) begin
            if (start_valid) begin
                ctl_d.state  = ST_HDR;
                ctl_d.is_fwh = start_fwh;
                ctl_d.is_wr  = start_wr;
                ctl_d.cnt    = '0;
                ctl_d.addr   = '0;
            end else begin
                ctl_d.state  = ST_IDLE;
            end
        end else begin
            unique case (ctl_q.state)
                ST_IDLE, ST_SKIP: ctl_d.state = ctl_q.state;
                ST_HDR: begin
                    ctl_d.cnt = '0;
                    if (ctl_q.is_fwh) begin
                        ctl_d.state = (bus_in == {1'b0, id_strap}) ? ST_ADDR : ST_SKIP;
                    end else if (bus_in == HDR_MEM_RD) begin
                        ctl_d.state = ST_ADDR;
                        ctl_d.is_wr = 1'b0;
                    end else if (bus_in == HDR_MEM_WR) begin
                        ctl_d.state = ST_ADDR;
                        ctl_d.is_wr = 1'b1;
                    end else begin
                        ctl_d.state = ST_SKIP;
                    end
                end
                ST_ADDR: begin
                    ctl_d.addr = addr_next;
                    ctl_d.cnt  = ctl_q.cnt + 1'b1;
                    if (ctl_q.is_fwh && ctl_q.cnt == FWH_ADDR_LAST) begin
                        ctl_d.state = ST_SIZE;
                    end else if (!ctl_q.is_fwh && ctl_q.cnt == LPC_ADDR_LAST) begin
                        ctl_d.cnt = '0;
                        if (addr_next[21:19] != ~id_strap) ctl_d.state = ST_SKIP;
                        else ctl_d.state = ctl_q.is_wr ? ST_WDATA : ST_TAR_IN;
                    end
                end
                ST_SIZE: begin
                    ctl_d.cnt = '0;
                    if (bus_in != SIZE_BYTE) ctl_d.state = ST_SKIP;
                    else ctl_d.state = ctl_q.is_wr ? ST_WDATA : ST_TAR_IN;
                end
                ST_WDATA: begin
                    if (ctl_q.cnt == '0) begin
                        ctl_d.wdata[3:0] = bus_in;
                        ctl_d.cnt        = 4'd1;
                    end else begin
                        ctl_d.wdata[7:4] = bus_in;
                        ctl_d.cnt        = '0;
                        ctl_d.state      = ST_TAR_IN;
                    end
                end
                ST_TAR_IN: begin
                    if (ctl_q.cnt == '0) begin
                        ctl_d.cnt = 4'd1;
                    end else begin
                        ctl_d.cnt      = '0;
                        ctl_d.state    = ST_SYNC;
                        ctl_d.wait_cnt = WAIT_W'(WAIT_CLKS);
                        acc_rd         = !ctl_q.is_wr;
                        acc_wr         = ctl_q.is_wr;
                    end
                end
                ST_SYNC: begin
                    if (ctl_q.wait_cnt != '0) ctl_d.wait_cnt = ctl_q.wait_cnt - 1'b1;
                    else ctl_d.state = ctl_q.is_wr ? ST_TAR_OUT : ST_RDATA;
                end
                ST_RDATA: begin
                    if (ctl_q.cnt == '0) begin
                        ctl_d.cnt = 4'd1;
                    end else begin
                        ctl_d.cnt   = '0;
                        ctl_d.state = ST_TAR_OUT;
                    end
                end
                ST_TAR_OUT: begin
                    if (ctl_q.cnt == '0) begin
                        ctl_d.cnt = 4'd1;
                    end else begin
                        ctl_d.cnt   = '0;
                        ctl_d.state = ST_IDLE;
                    end
                end
                default: ctl_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        bus_oe  = 1'b0;
        bus_out = '0;
        unique case (ctl_q.state)
            ST_SYNC: begin
                bus_oe  = 1'b1;
                bus_out = (ctl_q.wait_cnt != '0) ? SYNC_WAIT : SYNC_READY;
            end
            ST_RDATA: begin
                bus_oe  = 1'b1;
                bus_out = (ctl_q.cnt == '0) ? store_rdata[3:0] : store_rdata[7:4];
            end
            ST_TAR_OUT: begin
                bus_oe  = (ctl_q.cnt == '0);
                bus_out = (ctl_q.cnt == '0) ? NIB_TAR : '0;
            end
            default: begin
                bus_oe  = 1'b0;
                bus_out = '0;
            end
        endcase
    end

    // R12: a frame-low edge always leaves the bus released in the next clock
    assert_abort_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> !bus_oe);

    // R8: the first driven nibble of any response is a sync code
    assert_sync_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> (bus_out == ((WAIT_CLKS != 0) ? SYNC_WAIT : SYNC_READY)));

    // R8: while syncing with frame high, the target keeps driving
    assert_sync_continues_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_SYNC && frame_n) |=> bus_oe);

    // R11: the turnaround 1111 is followed by a released bus
    assert_release_after_tar_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && ctl_q.state == ST_TAR_OUT) |=> !bus_oe);
endmodule

// File: tb/sim_lpc_fwh_target.sv
module sim_lpc_fwh_target;
    localparam int         WAIT  = 2;
    localparam logic [2:0] STRAP = 3'd2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_n = 1'b1;
    logic [3:0] bus_in = 4'hF;
    logic [3:0] bus_out;
    logic       bus_oe;
    logic [2:0] id_strap = STRAP;

    int n_checks = 0;
    int n_errors = 0;
    logic       obs_oe;
    logic [3:0] obs_out;
    logic [7:0] mem [16];

    lpc_fwh_target #(.WAIT_CLKS(WAIT), .DEPTH(16)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .id_strap(id_strap)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic fr, input logic [3:0] nib);
        @(negedge clk);
        obs_oe  = bus_oe;
        obs_out = bus_out;
        frame_n = fr;
        bus_in  = nib;
    endtask

    task automatic quiet(input string tag, input logic fr, input logic [3:0] nib);
        step(fr, nib);
        chk(tag, int'(obs_oe), 0);
    endtask

    task automatic respond(input bit acc, input bit wr, input logic [3:0] idx,
                           input logic [7:0] wd, input string tag);
        if (wr) begin
            quiet({tag, " R7 wdata lo"}, 1'b1, wd[3:0]);
            quiet({tag, " R7 wdata hi"}, 1'b1, wd[7:4]);
        end
        quiet({tag, " R7 host tar"}, 1'b1, 4'hF);
        quiet({tag, " R7 host tar"}, 1'b1, 4'hF);
        if (acc) begin
            if (wr) mem[idx] = wd;
            for (int w = 0; w < WAIT; w++) begin
                step(1'b1, 4'hF);
                chk("R8 wait sync", int'({obs_oe, obs_out}), 'h15);
            end
            step(1'b1, 4'hF);
            chk("R8 ready sync", int'({obs_oe, obs_out}), 'h10);
            if (!wr) begin
                step(1'b1, 4'hF);
                chk("R9 R10 data lo", int'({obs_oe, obs_out}), int'({1'b1, mem[idx][3:0]}));
                step(1'b1, 4'hF);
                chk("R9 R10 data hi", int'({obs_oe, obs_out}), int'({1'b1, mem[idx][7:4]}));
            end
            step(1'b1, 4'hF);
            chk("R11 tar drive", int'({obs_oe, obs_out}), 'h1F);
            quiet("R11 release", 1'b1, 4'hF);
        end else begin
            for (int k = 0; k < WAIT + 3 + (wr ? 0 : 2); k++)
                quiet({tag, " ignored"}, 1'b1, 4'hF);
        end
    endtask

    function automatic logic [31:0] lpc_addr(input logic [2:0] hi3, input logic [3:0] idx);
        return {10'h2AB, hi3, 15'h1E3, idx};
    endfunction

    task automatic lpc_cycle(input bit first_chk, input logic [3:0] ct,
                             input logic [31:0] addr, input logic [7:0] wd, input string tag);
        bit acc;
        bit wr;
        step(1'b0, 4'h0);
        if (first_chk) chk({tag, " R7 start"}, int'(obs_oe), 0);
        quiet({tag, " R7 hdr"}, 1'b1, ct);
        for (int i = 7; i >= 0; i--) quiet({tag, " R7 addr"}, 1'b1, addr[i*4 +: 4]);
        wr  = (ct == 4'h6);
        acc = (ct == 4'h4 || ct == 4'h6) && (addr[21:19] == ~STRAP);
        respond(acc, wr, addr[3:0], wd, tag);
    endtask

    task automatic fwh_cycle(input bit first_chk, input bit wr, input logic [3:0] idsel,
                             input logic [27:0] addr, input logic [3:0] size,
                             input logic [7:0] wd, input string tag);
        bit acc;
        step(1'b0, wr ? 4'hE : 4'hD);
        if (first_chk) chk({tag, " R7 start"}, int'(obs_oe), 0);
        quiet({tag, " R7 idsel"}, 1'b1, idsel);
        for (int i = 6; i >= 0; i--) quiet({tag, " R7 addr"}, 1'b1, addr[i*4 +: 4]);
        quiet({tag, " R7 size"}, 1'b1, size);
        acc = (idsel == {1'b0, STRAP}) && (size == 4'h0);
        respond(acc, wr, addr[3:0], wd, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 4'hF);
        chk("R1 oe after reset", int'(obs_oe), 0);

        // R1: storage cleared, read through FWH before any write
        fwh_cycle(1, 0, {1'b0, STRAP}, {24'hF9E3C7, 4'd7}, 4'h0, 8'h00, "R1 R5");

        // R10 R4: LPC writes to every index, read back via FWH
        for (int a = 0; a < 16; a++)
            lpc_cycle(1, 4'h6, lpc_addr(~STRAP, 4'(a)), 8'((a * 37 + 11) & 255), "R4 R10");
        for (int a = 0; a < 16; a++)
            fwh_cycle(1, 0, {1'b0, STRAP}, {24'hF9E3C7, 4'(a)}, 4'h0, 8'h00, "R5 R9");
        // FWH writes, LPC reads
        for (int a = 0; a < 16; a++)
            fwh_cycle(1, 1, {1'b0, STRAP}, {24'h1C3A5B, 4'(a)}, 4'h0, 8'((a * 91 + 200) & 255), "R5 R10");
        for (int a = 0; a < 16; a++)
            lpc_cycle(1, 4'h4, lpc_addr(~STRAP, 4'(a)), 8'h00, "R3 R9");

        // R4: sweep address bits [21:19]
        for (int s = 0; s < 8; s++) begin
            lpc_cycle(1, 4'h6, lpc_addr(3'(s), 4'd11), 8'(8'h50 + s), "R4 strap");
            lpc_cycle(1, 4'h4, lpc_addr(~STRAP, 4'd11), 8'h00, "R4 readback");
        end

        // R3: every other LPC header is ignored
        for (int c = 0; c < 16; c++) begin
            if (c == 4 || c == 6) continue;
            lpc_cycle(1, 4'(c), lpc_addr(~STRAP, 4'd12), 8'h00, "R3 bad header");
        end
        lpc_cycle(1, 4'h4, lpc_addr(~STRAP, 4'd12), 8'h00, "R3 readback");

        // R5: sweep ID select
        for (int i = 0; i < 16; i++) begin
            fwh_cycle(1, 1, 4'(i), {24'h000000, 4'd9}, 4'h0, 8'(8'hC0 | i), "R5 idsel");
            lpc_cycle(1, 4'h4, lpc_addr(~STRAP, 4'd9), 8'h00, "R5 readback");
        end

        // R6: only single-byte size served
        for (int z = 1; z < 16; z++) begin
            fwh_cycle(1, 1, {1'b0, STRAP}, {24'h000000, 4'd10}, 4'(z), 8'(8'h30 + z), "R6 size");
            fwh_cycle(1, 0, {1'b0, STRAP}, {24'h000000, 4'd10}, 4'(z), 8'h00, "R6 size read");
        end
        fwh_cycle(1, 0, {1'b0, STRAP}, {24'h000000, 4'd10}, 4'h0, 8'h00, "R6 readback");

        // R2: invalid start nibbles carrying an otherwise valid LPC write
        for (int n = 0; n < 16; n++) begin
            if (n == 0 || n == 13 || n == 14) continue;
            quiet("R2 bad start", 1'b0, 4'(n));
            quiet("R2 bad start", 1'b1, 4'h6);
            for (int i = 7; i >= 0; i--) quiet("R2 bad start", 1'b1, lpc_addr(~STRAP, 4'd13) >> (i * 4));
            for (int k = 0; k < 12; k++) quiet("R2 bad start", 1'b1, 4'hA);
        end
        lpc_cycle(1, 4'h4, lpc_addr(~STRAP, 4'd13), 8'h00, "R2 readback");

        // R2: frame held low, last start nibble wins
        quiet("R2 multi start", 1'b0, 4'h3);
        fwh_cycle(1, 0, {1'b0, STRAP}, {24'h000000, 4'd3}, 4'h0, 8'h00, "R2 last start fwh");
        quiet("R2 multi start", 1'b0, 4'hD);
        lpc_cycle(1, 4'h4, lpc_addr(~STRAP, 4'd4), 8'h00, "R2 last start lpc");

        // R12: abort an LPC write mid-address, new FWH read starts at once
        quiet("R12 pre", 1'b0, 4'h0);
        quiet("R12 pre", 1'b1, 4'h6);
        for (int i = 7; i >= 4; i--) quiet("R12 pre", 1'b1, lpc_addr(~STRAP, 4'd5) >> (i * 4));
        fwh_cycle(1, 0, {1'b0, STRAP}, {24'h000000, 4'd5}, 4'h0, 8'h00, "R12 after abort");

        // R12: abort while the target drives sync
        quiet("R12 pre", 1'b0, 4'h0);
        quiet("R12 pre", 1'b1, 4'h4);
        for (int i = 7; i >= 0; i--) quiet("R12 pre", 1'b1, lpc_addr(~STRAP, 4'd6) >> (i * 4));
        quiet("R12 pre tar", 1'b1, 4'hF);
        quiet("R12 pre tar", 1'b1, 4'hF);
        step(1'b1, 4'hF);
        chk("R12 sync before abort", int'({obs_oe, obs_out}), 'h15);
        fwh_cycle(0, 0, {1'b0, STRAP}, {24'h000000, 4'd6}, 4'h0, 8'h00, "R12 sync abort");

        // R12: abort with invalid start just releases the bus
        quiet("R12 pre", 1'b0, 4'hD);
        quiet("R12 pre", 1'b1, {1'b0, STRAP});
        for (int i = 0; i < 7; i++) quiet("R12 pre", 1'b1, 4'h0);
        quiet("R12 pre", 1'b1, 4'h0);
        quiet("R12 pre tar", 1'b1, 4'hF);
        quiet("R12 pre tar", 1'b1, 4'hF);
        step(1'b0, 4'h9);
        chk("R12 sync before abort", int'({obs_oe, obs_out}), 'h15);
        for (int k = 0; k < 8; k++) quiet("R12 released", 1'b1, 4'hF);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule